// File: doc/BRIEF.md
# Pattern-Triggered Capture Controller

This block is the acquisition core of a small logic analyzer. On every edge of an externally supplied sample clock it registers a 16-bit data bus, compares the registered word against a ternary pattern (each bit is required-one, required-zero or ignored) and writes the word into a 16-entry circular buffer. Once the pattern is recognised, a programmable BCD delay runs. The delay counts either sample clocks or further pattern hits. The word at which the delay expires is the anchor.

After the anchor, acquisition continues for a number of words set by a placement select. The frozen buffer then holds the anchor at the start, in the middle or at the end of a 16-word window. A done flag and the buffer address of the anchor tell the display logic where to begin. In single mode the snapshot stays frozen until a restart pulse arrives or repetitive mode is selected. In repetitive mode the controller re-arms by itself one cycle after each capture.

Top module: `la_trigger_capture`

## Requirements
- R1: The bus is registered on each sample clock edge. The word present at edge k is the one compared during the following cycle and written to the buffer at edge k+1.
- R2: A registered word matches when, for every bit with `pat_care_i`=1, the bit equals `pat_val_i`. Bits with `pat_care_i`=0 are ignored, so a zero care mask matches every word.
- R3: While not done, every edge writes the registered word at the write address and then increments that address modulo 16. The 16 buffer words appear on `cap_bus_o`, word i at bits [16i+15:16i].
- R4: The delay, 4 BCD digits with a range of 0 to 9999, is taken from `delay_bcd_i` only on an edge where `delay_load_i` is 1. Changing `delay_bcd_i` at other times has no effect.
- R5: With `count_events_i`=0 and delay N, the anchor is the word sampled N clocks after the first matching word after arming. Later matches are ignored.
- R6: With `count_events_i`=1 and delay N, the first N matches after arming are skipped and the anchor is match number N+1.
- R7: `trig_addr_o` holds the buffer address of the anchor. Placement `place_i`=0 keeps the anchor and the 15 words after it. Placement 1 keeps 7 words before the anchor, the anchor and 8 words after it. Placement 2 or 3 keeps the anchor and the 15 words before it.
- R8: If the anchor is sampled at edge a, `done_o` rises at edge a+1+P, where P is 15, 8 or 0 for placements 0, 1 and 2/3.
- R9: In single mode (`repeat_i`=0) with no restart, `done_o`, `cap_bus_o` and `trig_addr_o` hold steady whatever the data bus carries.
- R10: In repetitive mode `done_o` is high for exactly one cycle. The controller then re-arms, and a later match yields a new capture with the same timing.
- R11: A `restart_i` pulse clears `done_o` at the next edge and re-arms. Raising `repeat_i` while done also re-arms.
- R12: After reset, `done_o` is 0, `trig_addr_o` is 0, the buffer is all zeros and the stored delay is 0.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Re-arm pulse; clears done |
| din_i | input | 16 | Data bus under observation |
| pat_val_i | input | 16 | Required bit values of the pattern |
| pat_care_i | input | 16 | Per-bit compare enable (0 = ignored) |
| delay_bcd_i | input | 16 | Delay value, four BCD digits |
| delay_load_i | input | 1 | Loads `delay_bcd_i` into the delay store |
| count_events_i | input | 1 | 1: delay counts matches; 0: delay counts clocks |
| place_i | input | 2 | Anchor placement: 0 start, 1 middle, 2/3 end |
| repeat_i | input | 1 | 1: automatic re-arm after each capture |
| cap_bus_o | output | 256 | Buffer contents, word i at bits [16i+15:16i] |
| done_o | output | 1 | Capture frozen |
| trig_addr_o | output | 4 | Buffer address of the anchor word |

## Verification
A fault in the delay counter or the arming state moves the anchor. The effect shows on the ports as `done_o` rising in the wrong cycle, and as the word at `trig_addr_o` differing from the bus value sampled at the expected edge. Both are visible at the end of the same capture, at most 16 clocks after the anchor. A wrong write pointer or a missed freeze corrupts the neighbouring words in the snapshot. Those words are compared against the bench's own record of the bus, and they are checked again a few clocks later to catch any drift while frozen. BCD borrow faults appear only with delays that cross a digit boundary, so delays such as 100 and 1000 run the full decade chain.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_DELAY = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    localparam logic [1:0] PLACE_START  = 2'd0;
    localparam logic [1:0] PLACE_MIDDLE = 2'd1;
    localparam logic [1:0] PLACE_END    = 2'd2;

endpackage

// File: rtl/la_ternary_match.sv
module la_ternary_match #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] val_i,
    input  logic [DW-1:0] care_i,
    output logic          hit_o
);
    logic [DW-1:0] bit_ok;

    genvar g;
    for (g = 0; g < DW; g++) begin : g_bit
        logic true_term;
        logic inv_term;
        // true and inverted copies of the sampled bit, selected by the pattern value
        assign true_term = word_i[g] & val_i[g];
        assign inv_term  = ~word_i[g] & ~val_i[g];
        assign bit_ok[g] = ~care_i[g] | true_term | inv_term;
    end

    assign hit_o = &bit_ok;

endmodule

// File: rtl/la_bcd_down.sv
module la_bcd_down #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] value_i,
    output logic [4*DIGITS-1:0] value_o
);
    genvar g;
    for (g = 0; g < DIGITS; g++) begin : g_digit
        logic       borrow;
        logic [3:0] dig;
        if (g == 0) begin : g_lsd
            assign borrow = 1'b1;
        end else begin : g_upper
            // a digit decrements only when every lower digit is zero
            assign borrow = (value_i[4*g-1:0] == '0);
        end
        assign dig = value_i[4*g +: 4];
        assign value_o[4*g +: 4] = !borrow        ? dig :
                                   (dig == 4'd0)  ? 4'd9 :
                                                    dig - 4'd1;
    end

endmodule

// File: rtl/la_word_store.sv
module la_word_store #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [AW-1:0]            waddr_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [DW*(1<<AW)-1:0]    words_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    genvar g;
    for (g = 0; g < DEPTH; g++) begin : g_out
        assign words_o[g*DW +: DW] = mem_q[g];
    end

    // R3: an enabled write lands at the addressed word
    p_store_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

endmodule

// File: rtl/la_trigger_capture.sv
module la_trigger_capture
    import la_cap_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart_i,
    input  logic [DW-1:0]           din_i,
    input  logic [DW-1:0]           pat_val_i,
    input  logic [DW-1:0]           pat_care_i,
    input  logic [4*DIGITS-1:0]     delay_bcd_i,
    input  logic                    delay_load_i,
    input  logic                    count_events_i,
    input  logic [1:0]              place_i,
    input  logic                    repeat_i,
    output logic [DW*(1<<AW)-1:0]   cap_bus_o,
    output logic                    done_o,
    output logic [AW-1:0]           trig_addr_o
);
    localparam int             DEPTH       = 1 << AW;
    localparam int             CW          = 4 * DIGITS;
    localparam logic [AW-1:0]  TAIL_START  = AW'(DEPTH - 1);
    localparam logic [AW-1:0]  TAIL_MIDDLE = AW'(DEPTH / 2);

    typedef struct packed {
        cap_state_e     state;
        logic [AW-1:0]  wr;
        logic [AW-1:0]  trig;
        logic [AW-1:0]  rem;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  store;
        logic [DW-1:0]  sample;
    } ctl_t;

    ctl_t           c_d, c_q;
    logic           hit;
    logic           anchor;
    logic           wr_en;
    logic [CW-1:0]  cnt_dec;
    logic [AW-1:0]  tail_len;

    la_ternary_match #(.DW(DW)) u_match (
        .word_i (c_q.sample),
        .val_i  (pat_val_i),
        .care_i (pat_care_i),
        .hit_o  (hit)
    );

    la_bcd_down #(.DIGITS(DIGITS)) u_dec (
        .value_i (c_q.cnt),
        .value_o (cnt_dec)
    );

    la_word_store #(.DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (c_q.wr),
        .wdata_i (c_q.sample),
        .words_o (cap_bus_o)
    );

    // words still to be written after the anchor
    always_comb begin
        case (place_i)
            PLACE_START:  tail_len = TAIL_START;
            PLACE_MIDDLE: tail_len = TAIL_MIDDLE;
            default:      tail_len = '0;
        endcase
    end

    always_comb begin
        c_d        = c_q;
        anchor     = 1'b0;
        wr_en      = (c_q.state != ST_DONE);
        c_d.sample = din_i;

        if (delay_load_i) begin
            c_d.store = delay_bcd_i;
        end
        if (wr_en) begin
            c_d.wr = c_q.wr + 1'b1;
        end

        case (c_q.state)
            ST_ARMED: begin
                if (hit) begin
                    if (c_q.store == '0) begin
                        anchor = 1'b1;
                    end else begin
                        c_d.cnt   = c_q.store;
                        c_d.state = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                if (!count_events_i || hit) begin
                    if (c_q.cnt == CW'(1)) begin
                        anchor = 1'b1;
                    end else begin
                        c_d.cnt = cnt_dec;
                    end
                end
            end
            ST_POST: begin
                if (c_q.rem == AW'(1)) begin
                    c_d.state = ST_DONE;
                end else begin
                    c_d.rem = c_q.rem - 1'b1;
                end
            end
            ST_DONE: begin
                if (repeat_i) begin
                    c_d.state = ST_ARMED;
                end
            end
            default: c_d.state = ST_ARMED;
        endcase

        if (anchor) begin
            c_d.trig = c_q.wr;
            if (tail_len == '0) begin
                c_d.state = ST_DONE;
            end else begin
                c_d.rem   = tail_len;
                c_d.state = ST_POST;
            end
        end

        if (restart_i) begin
            c_d.state = ST_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_ARMED;
            c_q.wr     <= '0;
            c_q.trig   <= '0;
            c_q.rem    <= '0;
            c_q.cnt    <= '0;
            c_q.store  <= '0;
            c_q.sample <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done_o      = (c_q.state == ST_DONE);
    assign trig_addr_o = c_q.trig;

    // R2: an empty care mask accepts any sampled word
    p_dontcare_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_care_i == '0) |-> hit);

    // R5: a running delay never sits at zero
    p_delay_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_DELAY) |-> (c_q.cnt != '0));

    genvar g;
    for (g = 0; g < DIGITS; g++) begin : g_chk
        // R4: decimal digits of the running count stay in 0..9
        p_digit_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (c_q.state == ST_DELAY) |-> (c_q.cnt[4*g +: 4] <= 4'd9));
    end

    // R7: the anchor address holds while the tail is collected
    p_trig_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_POST) |=> $stable(trig_addr_o));

    // R9: a single-mode snapshot stays frozen
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !restart_i && !repeat_i) |=>
            (done_o && $stable(cap_bus_o) && $stable(trig_addr_o)));

    // R11: restart always clears done
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !done_o);

endmodule

// File: tb/test_la_trigger_capture.sv
module test_la_trigger_capture;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart = 1'b0;
    logic [15:0]  din = '0;
    logic [15:0]  pat_val = '0;
    logic [15:0]  pat_care = '0;
    logic [15:0]  delay_bcd = '0;
    logic         delay_load = 1'b0;
    logic         count_events = 1'b0;
    logic [1:0]   place = 2'd0;
    logic         repeat_mode = 1'b0;
    logic [255:0] cap_bus;
    logic         done;
    logic [3:0]   trig;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n      = 0;
    logic [15:0] hist [64];
    logic        dnh  [64];
    logic [15:0] pat, care;

    la_trigger_capture i_la_trigger_capture (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart_i      (restart),
        .din_i          (din),
        .pat_val_i      (pat_val),
        .pat_care_i     (pat_care),
        .delay_bcd_i    (delay_bcd),
        .delay_load_i   (delay_load),
        .count_events_i (count_events),
        .place_i        (place),
        .repeat_i       (repeat_mode),
        .cap_bus_o      (cap_bus),
        .done_o         (done),
        .trig_addr_o    (trig)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        int t = v;
        for (int d = 0; d < 4; d++) begin
            r[4*d +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic bit is_match(input logic [15:0] w);
        return ((w ^ pat) & care) == 16'h0;
    endfunction

    function automatic logic [15:0] nomatch();
        logic [15:0] w = 16'($urandom);
        if (is_match(w)) w = w ^ (care & (~care + 16'd1));
        return w;
    endfunction

    function automatic logic [15:0] mword();
        return (16'($urandom) & ~care) | (pat & care);
    endfunction

    task automatic step(input logic [15:0] w);
        din = w;
        @(posedge clk);
        #1;
    endtask

    task automatic step_rec(input logic [15:0] w);
        din = w;
        hist[n & 63] = w;
        @(posedge clk);
        #1;
        dnh[n & 63] = done;
        n++;
    endtask

    task automatic run_cap(input int plc, input bit ev, input int nd, input bit rep,
                           input bit noisy);
        int rlen, a, hits, done_at, lo;
        bit seek;
        logic [255:0] snap;
        logic [3:0]   tsnap;
        logic [15:0]  w;
        rlen = (plc == 0) ? 15 : (plc == 1) ? 8 : 0;
        pat  = 16'($urandom);
        care = 16'($urandom);
        if (care == 16'h0) care = 16'h0100;
        pat_val = pat; pat_care = care; place = 2'(plc);
        count_events = ev; repeat_mode = rep;
        delay_bcd = to_bcd(nd); delay_load = 1'b1;
        step(nomatch());
        delay_load = 1'b0;
        delay_bcd = to_bcd(int'($urandom % 10000));   // R4: ignored without load
        restart = 1'b1;
        step(nomatch());
        restart = 1'b0;
        n = 0; a = -1; hits = 0; done_at = -1; seek = 1'b1;
        snap = '0; tsnap = '0;
        while ((a < 0 || n <= a + rlen + 3) && n < 12000) begin
            if (n < 20) w = nomatch();
            else if (ev) w = (n > 220 || ($urandom % 3) == 0) ? mword() : nomatch();
            else if (n == 20) w = mword();
            else w = noisy ? 16'($urandom) : nomatch();
            if (n >= 20 && a < 0) begin
                if (ev) begin
                    if (is_match(w)) begin
                        hits++;
                        if (hits == nd + 1) a = n;
                    end
                end else if (n == 20) begin
                    a = 20 + nd;
                end
            end
            step_rec(w);
            if (seek && done) begin
                done_at = n - 1; seek = 1'b0; snap = cap_bus; tsnap = trig;
            end
        end
        chk("R8", done_at, a + 1 + rlen, "done rise step");
        chk(ev ? "R6 R2" : "R5 R1", snap[int'(tsnap)*16 +: 16], hist[a & 63], "anchor word");
        lo = (plc == 0) ? 0 : (plc == 1) ? -7 : -15;
        for (int o = lo; o < lo + 16; o++) begin
            chk("R3 R7", snap[((int'(tsnap) + o) & 15)*16 +: 16], hist[(a + o) & 63],
                "window word");
        end
        if (!rep) begin
            for (int k = 0; k < 4; k++) step_rec(mword());
            chk("R9", done, 1'b1, "done held");
            chk("R9", cap_bus == snap, 1'b1, "buffer frozen");
            chk("R9", trig, tsnap, "anchor address held");
        end else begin
            int base, stop, done2;
            chk("R10", dnh[(done_at + 1) & 63], 1'b0, "done one cycle");
            base = n + 3; stop = base + nd + rlen + 4; done2 = -1; seek = 1'b1;
            while (n < stop) begin
                w = (n == base) ? mword() : nomatch();
                step_rec(w);
                if (seek && done && (n - 1) > done_at) begin
                    done2 = n - 1; seek = 1'b0; snap = cap_bus; tsnap = trig;
                end
            end
            chk("R10", done2, base + nd + 1 + rlen, "second capture timing");
            chk("R10", snap[int'(tsnap)*16 +: 16], hist[(base + nd) & 63],
                "second anchor word");
        end
        restart = 1'b1;
        step(nomatch());
        restart = 1'b0;
        chk("R11", done, 1'b0, "restart clears done");
        repeat_mode = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R12", done, 1'b0, "reset done");
        chk("R12", trig, 4'd0, "reset anchor address");
        chk("R12", cap_bus == '0, 1'b1, "reset buffer");
        // R12: stored delay is zero, so a first match anchors at once
        pat = 16'hA5C3; care = 16'hFFFF; pat_val = pat; pat_care = care; place = 2'd2;
        for (int k = 0; k < 18; k++) step(nomatch());
        step(pat);
        step(nomatch());
        chk("R12", done, 1'b1, "zero delay after reset");
        chk("R12", cap_bus[int'(trig)*16 +: 16], pat, "anchor after reset");

        // directed: placements with clock delay 0
        run_cap(0, 1'b0, 0, 1'b0, 1'b0);
        run_cap(1, 1'b0, 0, 1'b0, 1'b0);
        run_cap(2, 1'b0, 0, 1'b0, 1'b0);
        run_cap(3, 1'b0, 0, 1'b0, 1'b0);
        // directed: clock delays crossing BCD boundaries
        run_cap(1, 1'b0, 5, 1'b0, 1'b1);
        run_cap(2, 1'b0, 100, 1'b0, 1'b1);
        run_cap(0, 1'b0, 1000, 1'b0, 1'b1);
        run_cap(0, 1'b0, 9999, 1'b0, 1'b1);
        // directed: event delays
        run_cap(0, 1'b1, 0, 1'b0, 1'b0);
        run_cap(1, 1'b1, 1, 1'b0, 1'b0);
        run_cap(2, 1'b1, 3, 1'b0, 1'b0);
        // repetitive mode
        run_cap(1, 1'b0, 2, 1'b1, 1'b0);
        run_cap(2, 1'b0, 0, 1'b1, 1'b0);
        // R11: selecting repetitive mode re-arms a frozen single capture
        pat = 16'h0F0F; care = 16'h00FF; pat_val = pat; pat_care = care; place = 2'd2;
        delay_bcd = '0; delay_load = 1'b1; step(nomatch()); delay_load = 1'b0;
        restart = 1'b1; step(nomatch()); restart = 0;
        step(mword()); step(nomatch());
        chk("R11", done, 1'b1, "single capture frozen");
        repeat_mode = 1'b1; step(nomatch()); repeat_mode = 1'b0;
        chk("R11", done, 1'b0, "repetitive select re-arms");
        // constrained random single-mode runs
        for (int r = 0; r < 14; r++) begin
            bit ev = 1'($urandom);
            run_cap(int'($urandom % 4), ev,
                    ev ? int'($urandom % 6) : int'($urandom % 300), 1'b0, 1'($urandom));
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule